// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Recorder

This block watches firmware from a slow, always-on clock and pulls the system into reset when firmware stops checking in. The watchdog counter runs on the low-frequency clock, so it keeps counting while the main clock is gated off in deep sleep. Firmware sets a 16-bit timeout and must write a fixed key to a service register often enough. If it does not, the counter reaches the timeout and the block drives its system reset output for a fixed number of slow-clock periods.

The block also merges three reset requests: watchdog expiry, a software request and an active-low external reset pin. Any of them asserts the reset output at once, without waiting for a clock edge. Release is synchronized to the main clock. A three-bit cause register remembers which sources fired. Only the power-on input or a write-one-to-clear from firmware clears it; the system reset it caused leaves it alone. Register access uses a simple write strobe with a combinational read path, both on the main clock.

Register map (2-bit address): 0 = timeout (read/write, 16 bits), 1 = service (write only, reads 0), 2 = cause (read, write-one-to-clear), 3 = control (write only, reads 0).

Top module: `wdg_rstcause_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high. After power-on, the timeout register and the cause register both read 0, and `sys_rst_o` goes low within 3 main-clock cycles of `por_i` falling.
- R2: A timeout value of 0 disables the watchdog: no watchdog reset occurs however long firmware leaves it unserviced.
- R3: With a nonzero timeout T written while the watchdog was disabled and no service afterwards, `sys_rst_o` rises T (at most T+1) slow-clock rising edges after the write.
- R4: A watchdog expiry holds `sys_rst_o` high for RST_HOLD slow-clock periods (default 4), plus at most three main-clock cycles for the synchronized release.
- R5: Writing the key 16'hC3E1 to address 1 reloads the count to zero, taking effect within 3 slow-clock edges. Servicing more often than the timeout prevents any reset. After the last service, expiry follows in T+1 to T+4 slow-clock edges.
- R6: Writing any value other than 16'hC3E1 to address 1 has no effect on the count.
- R7: Cause register bit 0 records a watchdog reset, bit 1 a software reset and bit 2 an external-pin reset. Each bit is set by its source and stays set through the system reset.
- R8: Writing to address 2 clears exactly those cause bits written as 1. Bits written as 0 keep their value.
- R9: Writing 1 to bit 0 of address 3 asserts `sys_rst_o` from the next main-clock edge and releases it within 4 cycles. Writing 0 there has no effect.
- R10: `ext_rst_n_i` low asserts `sys_rst_o` immediately, without a clock edge. `sys_rst_o` falls within 4 main-clock cycles after the pin returns high.
- R11: A `por_i` pulse clears the cause register and the timeout register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main system clock for the register port and reset release |
| lf_clk_i | input | 1 | Slow always-on clock driving the watchdog counter |
| por_i | input | 1 | Power-on reset, active high, synchronous in each domain |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| sys_rst_o | output | 1 | System reset output, active high |

## Verification
On every cycle, the assertions check four things. A wrong key never disturbs the service toggle. Cause bits never fall except by a matching write-one-to-clear. An active reset source always holds the output high. A watchdog expiry never starts while the timeout is zero. Only the bench scenarios can show the timing across the two clocks: how many slow-clock edges pass before expiry for each timeout in a sweep, how long the reset pulse lasts, and whether periodic servicing holds expiry off indefinitely. These measurements depend on the phase between the two clocks, which a single-clock property cannot see.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned REG_DW = 16;
    localparam int unsigned CAUSE_W = 3;

    typedef enum logic [1:0] {
        REG_TIMEOUT = 2'd0,
        REG_SERVICE = 2'd1,
        REG_CAUSE   = 2'd2,
        REG_CONTROL = 2'd3
    } reg_addr_e;

    // bit 0 watchdog, bit 1 software, bit 2 external pin
    typedef struct packed {
        logic ext;
        logic sw;
        logic wdt;
    } cause_t;

    localparam logic [REG_DW-1:0] SERVICE_KEY = 16'hC3E1;

    function automatic logic [CAUSE_W-1:0] cause_update(
        input logic [CAUSE_W-1:0] cur,
        input logic [CAUSE_W-1:0] set,
        input logic [CAUSE_W-1:0] clr
    );
        // a source firing in the same cycle as a clear wins
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/wdg_lf_timer.sv
module wdg_lf_timer #(
    parameter int unsigned CW       = 16,
    parameter int unsigned RST_HOLD = 4
) (
    input  logic          lf_clk_i,
    input  logic          por_i,
    input  logic [CW-1:0] timeout_i,
    input  logic          svc_tgl_i,
    output logic          fire_o
);

    localparam int unsigned HW = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [HW-1:0] HOLD_INIT = HW'(RST_HOLD - 1);

    logic [CW-1:0] cnt_q;
    logic [HW-1:0] hold_q;
    logic          fire_q;
    logic          svc_s;
    logic          svc_d_q;
    logic          svc_pulse;

    wdg_sync2 #(.WIDTH(1)) u_svc_sync (
        .clk_i (lf_clk_i),
        .rst_i (por_i),
        .d_i   (svc_tgl_i),
        .q_o   (svc_s)
    );

    assign svc_pulse = svc_s ^ svc_d_q;

    always_ff @(posedge lf_clk_i) begin
        if (por_i) begin
            cnt_q   <= '0;
            hold_q  <= '0;
            fire_q  <= 1'b0;
            svc_d_q <= 1'b0;
        end else begin
            svc_d_q <= svc_s;
            if (fire_q) begin
                cnt_q <= '0;
                if (hold_q == '0) begin
                    fire_q <= 1'b0;
                end else begin
                    hold_q <= hold_q - 1'b1;
                end
            end else if ((timeout_i == '0) || svc_pulse) begin
                cnt_q <= '0;
            end else if (cnt_q == timeout_i - 1'b1) begin
                cnt_q  <= '0;
                fire_q <= 1'b1;
                hold_q <= HOLD_INIT;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fire_o = fire_q;

    // R2: expiry can only start while a nonzero timeout is programmed
    a_r2_no_fire_disabled: assert property (@(posedge lf_clk_i) disable iff (por_i)
        $rose(fire_q) |-> ($past(timeout_i) != '0));

    // R5: an accepted service leaves the count at zero
    a_r5_service_reload: assert property (@(posedge lf_clk_i) disable iff (por_i)
        (svc_pulse && !fire_q) |=> (cnt_q == '0));

    // R4: a reset pulse lasts at least one further slow period
    a_r4_hold_min: assert property (@(posedge lf_clk_i) disable iff (por_i)
        $rose(fire_q) |=> fire_q);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    input  logic              wdt_fire_i,
    input  logic              ext_rst_n_i,
    output logic [REG_DW-1:0] rdata_o,
    output logic [CW-1:0]     timeout_o,
    output logic              svc_tgl_o,
    output logic              sw_req_o
);

    logic [1:0]         async_src;
    logic [1:0]         src_s;
    logic [CW-1:0]      timeout_q;
    logic               svc_tgl_q;
    logic               sw_req_q;
    cause_t             cause_q;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;
    reg_addr_e          addr_e;

    assign async_src = {~ext_rst_n_i, wdt_fire_i};

    wdg_sync2 #(.WIDTH(2)) u_src_sync (
        .clk_i (clk_i),
        .rst_i (por_i),
        .d_i   (async_src),
        .q_o   (src_s)
    );

    assign addr_e  = reg_addr_e'(addr_i);
    assign set_vec = {src_s[1], sw_req_q, src_s[0]};
    assign clr_vec = (wr_en_i && addr_e == REG_CAUSE) ? wdata_i[CAUSE_W-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            timeout_q <= '0;
            svc_tgl_q <= 1'b0;
            sw_req_q  <= 1'b0;
            cause_q   <= '0;
        end else begin
            sw_req_q <= wr_en_i && (addr_e == REG_CONTROL) && wdata_i[0];
            if (wr_en_i && addr_e == REG_TIMEOUT) begin
                timeout_q <= wdata_i[CW-1:0];
            end
            if (wr_en_i && addr_e == REG_SERVICE && wdata_i == SERVICE_KEY) begin
                svc_tgl_q <= ~svc_tgl_q;
            end
            cause_q <= cause_t'(cause_update(cause_q, set_vec, clr_vec));
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_e)
            REG_TIMEOUT: rdata_o[CW-1:0] = timeout_q;
            REG_CAUSE:   rdata_o[CAUSE_W-1:0] = cause_q;
            default:     rdata_o = '0;
        endcase
    end

    assign timeout_o = timeout_q;
    assign svc_tgl_o = svc_tgl_q;
    assign sw_req_o  = sw_req_q;

    // R6: a wrong key leaves the service toggle untouched
    a_r6_bad_key_ignored: assert property (@(posedge clk_i) disable iff (por_i)
        (wr_en_i && addr_i == 2'd1 && wdata_i != SERVICE_KEY) |=> $stable(svc_tgl_q));

    // R7: without a clearing write no cause bit ever falls
    a_r7_cause_sticky: assert property (@(posedge clk_i) disable iff (por_i)
        !(wr_en_i && addr_i == 2'd2) |=> (($past(cause_q) & ~cause_q) == '0));

    // R8: bits written as one are clear afterwards unless re-set
    a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (por_i)
        (wr_en_i && addr_i == 2'd2) |=>
            ((cause_q & $past(wdata_i[CAUSE_W-1:0] & ~set_vec)) == '0));

endmodule

// File: rtl/wdg_rst_gen.sv
module wdg_rst_gen (
    input  logic clk_i,
    input  logic por_i,
    input  logic wdt_fire_i,
    input  logic sw_req_i,
    input  logic ext_rst_n_i,
    output logic sys_rst_o
);

    logic       req_any;
    logic [1:0] rel_q;

    assign req_any = por_i | wdt_fire_i | sw_req_i | ~ext_rst_n_i;

    always_ff @(posedge clk_i or posedge req_any) begin
        if (req_any) begin
            rel_q <= 2'b11;
        end else begin
            rel_q <= {rel_q[0], 1'b0};
        end
    end

    assign sys_rst_o = rel_q[1];

    // R10: the pin held low always keeps the reset asserted
    a_r10_ext_holds: assert property (@(posedge clk_i) disable iff (por_i)
        !ext_rst_n_i |-> sys_rst_o);

    // R9: a software request is visible on the output
    a_r9_sw_asserts: assert property (@(posedge clk_i) disable iff (por_i)
        sw_req_i |-> sys_rst_o);

    // R4: a watchdog expiry is visible on the output
    a_r4_fire_asserts: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_fire_i |-> sys_rst_o);

endmodule

// File: rtl/wdg_rstcause_top.sv
module wdg_rstcause_top
    import wdg_pkg::*;
#(
    parameter int unsigned CW       = 16,
    parameter int unsigned RST_HOLD = 4
) (
    input  logic              clk_i,
    input  logic              lf_clk_i,
    input  logic              por_i,
    input  logic              ext_rst_n_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    output logic [REG_DW-1:0] rdata_o,
    output logic              sys_rst_o
);

    logic [CW-1:0] timeout;
    logic          svc_tgl;
    logic          sw_req;
    logic          wdt_fire;

    wdg_regs #(.CW(CW)) u_regs (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .wdt_fire_i  (wdt_fire),
        .ext_rst_n_i (ext_rst_n_i),
        .rdata_o     (rdata_o),
        .timeout_o   (timeout),
        .svc_tgl_o   (svc_tgl),
        .sw_req_o    (sw_req)
    );

    wdg_lf_timer #(.CW(CW), .RST_HOLD(RST_HOLD)) u_timer (
        .lf_clk_i  (lf_clk_i),
        .por_i     (por_i),
        .timeout_i (timeout),
        .svc_tgl_i (svc_tgl),
        .fire_o    (wdt_fire)
    );

    wdg_rst_gen u_rst (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .wdt_fire_i  (wdt_fire),
        .sw_req_i    (sw_req),
        .ext_rst_n_i (ext_rst_n_i),
        .sys_rst_o   (sys_rst_o)
    );

endmodule

// File: tb/sim_wdg_rstcause_top.sv
module sim_wdg_rstcause_top;

    localparam int    HOLD   = 4;
    localparam int    LF_HP  = 200;
    localparam int    LF_P   = 2 * LF_HP;
    localparam [15:0] KEY    = 16'hC3E1;

    logic        clk = 1'b0;
    logic        lf_clk = 1'b0;
    logic        por = 1'b1;
    logic        ext_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        sys_rst;

    int checks = 0;
    int fails = 0;
    int lf_cnt = 0;
    bit rst_seen = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always #(LF_HP) lf_clk = ~lf_clk;
    always @(posedge lf_clk) lf_cnt++;
    always @(posedge clk) if (sys_rst) rst_seen = 1'b1;

    wdg_rstcause_top #(.CW(16), .RST_HOLD(HOLD)) u0 (
        .clk_i       (clk),
        .lf_clk_i    (lf_clk),
        .por_i       (por),
        .ext_rst_n_i (ext_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .sys_rst_o   (sys_rst)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_release();
        int guard = 0;
        while (sys_rst && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_lf(input int n);
        repeat (n) @(posedge lf_clk);
    endtask

    initial begin
        #(64'd200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run hung)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int lf0, n;
        realtime t0, dur;

        // R1: reset state
        wait_lf(4);
        @(negedge clk);
        check(sys_rst == 1'b1, "R1 reset during por", sys_rst, 1);
        por = 1'b0;
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b0, "R1 release after por", sys_rst, 0);
        rd(2'd0, v); check(v == 16'd0, "R1 timeout after por", v, 0);
        rd(2'd2, v); check(v == 16'd0, "R1 cause after por", v, 0);

        // R2: timeout 0 never expires
        rst_seen = 1'b0;
        wait_lf(30);
        check(rst_seen == 1'b0, "R2 disabled watchdog quiet", rst_seen, 0);

        // R3 / R4 / R7 / R8: sweep of timeouts without service
        for (int t = 1; t <= 10; t++) begin
            wr(2'd0, 16'(t));
            lf0 = lf_cnt;
            wait (sys_rst);
            t0 = $realtime;
            n = lf_cnt - lf0;
            check(n >= t && n <= t + 1, "R3 expiry edges", n, t);
            wr(2'd0, 16'd0);
            wait (!sys_rst);
            dur = $realtime - t0;
            check(dur >= HOLD * LF_P && dur <= HOLD * LF_P + 80, "R4 reset width ns",
                  longint'(dur), HOLD * LF_P);
            repeat (2) @(negedge clk);
            rd(2'd2, v); check(v == 16'd1, "R7 watchdog cause bit0", v, 1);
            wr(2'd2, 16'd1);
            rd(2'd2, v); check(v == 16'd0, "R8 cause bit0 cleared", v, 0);
        end

        // R5: regular service holds off expiry, then expiry follows
        wr(2'd0, 16'd8);
        rst_seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            wait_lf(4);
            wr(2'd1, KEY);
        end
        check(rst_seen == 1'b0, "R5 serviced no reset", rst_seen, 0);
        lf0 = lf_cnt;
        wait (sys_rst);
        n = lf_cnt - lf0;
        check(n >= 9 && n <= 12, "R5 expiry after last service", n, 9);
        wr(2'd0, 16'd0);
        wait_release();
        repeat (3) @(negedge clk);
        wr(2'd2, 16'd7);

        // R6: wrong keys do not reload
        wr(2'd0, 16'd6);
        lf0 = lf_cnt;
        while (!sys_rst) begin
            wait_lf(2);
            if (!sys_rst) wr(2'd1, KEY ^ 16'h0101);
        end
        n = lf_cnt - lf0;
        check(n >= 6 && n <= 7, "R6 wrong key ignored", n, 6);
        wr(2'd0, 16'd0);
        wait_release();
        repeat (3) @(negedge clk);
        wr(2'd2, 16'd7);
        rd(2'd2, v); check(v == 16'd0, "R8 all cleared", v, 0);

        // R9: software reset
        rst_seen = 1'b0;
        wr(2'd3, 16'd0);
        repeat (4) @(negedge clk);
        check(rst_seen == 1'b0, "R9 control bit0 zero no effect", rst_seen, 0);
        wr(2'd3, 16'd1);
        check(sys_rst == 1'b1, "R9 sw reset asserted", sys_rst, 1);
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b0, "R9 sw reset released", sys_rst, 0);
        rd(2'd2, v); check(v == 16'd2, "R7 sw cause bit1", v, 2);

        // R10: external pin
        @(negedge clk);
        ext_n = 1'b0;
        #1 check(sys_rst == 1'b1, "R10 pin asserts immediately", sys_rst, 1);
        repeat (5) @(negedge clk);
        ext_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b0, "R10 release after pin", sys_rst, 0);
        rd(2'd2, v); check(v == 16'd6, "R7 ext bit2 and sticky sw bit1", v, 6);
        wr(2'd2, 16'd2);
        rd(2'd2, v); check(v == 16'd4, "R8 only written bit cleared", v, 4);

        // R11: power-on clears cause and timeout
        wr(2'd0, 16'd300);
        rd(2'd0, v); check(v == 16'd300, "R11 timeout written", v, 300);
        @(negedge clk);
        por = 1'b1;
        wait_lf(3);
        @(negedge clk);
        por = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check(v == 16'd0, "R11 timeout cleared", v, 0);
        rd(2'd2, v); check(v == 16'd0, "R11 cause cleared", v, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule